// File: doc/BRIEF.md
# Data MMU Access Checker with Fault Status Capture

This block sits beside the translation lookaside buffer of a data memory management unit. For every data access it examines the access attributes together with the TLB lookup result and the attributes of the page that was hit. The attributes of the access are the direction, the privilege level, the operand size, address masking, real mode and whether the address space is a no-fault one. It reports the first fault that applies, as a small result code in the same cycle. It also tells the memory pipeline whether a clean translation must be treated as uncacheable and strictly ordered.

When a fault occurs, three software-visible registers are loaded in the following clock cycle. The fault status word records the cause, the direction, the context class and the address-space identifier. The fault address register holds the effective virtual address. The tag-access register holds the page number and context that trap handlers need to refill the TLB. Software may overwrite the status word to clear it, and a second recorded fault before that clear sets an overflow bit. The TLB storage itself and the delivery of traps lie outside this block.

Top module: `dmmu_fault_check`

## Requirements
- R1: With `acc_valid` high, `fault_code` gives the first fault that applies, taken in this order: 1 misaligned, 2 address in the unimplemented hole, 3 or 4 TLB miss, 5 user access to a privileged page, 6 write to a read-only page, 7 no-fault-only page used through a normal address space, 8 side-effect page used through a no-fault address space. The code is 0 when no fault applies, and `fault` is high exactly when the code is nonzero.
- R2: An access is misaligned when the low three bits of `acc_va` ANDed with (2^`acc_size` − 1) are nonzero. `acc_size` is the log2 of the operand bytes.
- R3: The effective address is `acc_va` with the bits above bit 31 cleared when `acc_va_mask` is high, and `acc_va` unchanged otherwise. The hole fault applies only with masking off, when the effective address lies within [HOLE_LO, HOLE_HI].
- R4: A TLB miss reports code 3 when `acc_real` is high and code 4 otherwise.
- R5: A recorded fault loads `status` as follows: bit 0 = 1, bit 2 = write flag, bit 3 = 0, bits 5:4 = `acc_ctx_type`, bit 6 = side-effect flag, bits 12:7 = 6-bit fault type, bits 15:13 = 0, bits from 16 upward = `acc_asi`.
- R6: On a recorded fault, bit 1 of `status` becomes the previous value of bit 0, which marks an overflow.
- R7: The following faults are recorded. Code 1 records write flag 0, side-effect flag 0 and type 0 (other). Code 2 records write flag 0, side-effect flag 1 and type 3 (address out of range). Codes 5 to 8 record the write flag from `acc_write` and the side-effect flag from `pg_side_effect`. Their types are 1 (privilege violation) for code 5, 0 for code 6, 2 (load from no-fault page) for code 7 and 4 (side effect) for code 8. Type 5 marks an illegal address space. Misses (codes 3 and 4) leave `status` and `fault_addr` unchanged.
- R8: Every recorded fault loads `fault_addr` with the effective address.
- R9: Misses and codes 5 to 8 load `tag_access` with effective-address bits 63:13 above a 13-bit context. The context is `acc_ctx`, or zero when `acc_real` is high. Codes 1 and 2 leave `tag_access` unchanged.
- R10: `uncacheable` is high exactly when a valid access has no fault and either `pg_side_effect` is high or `pg_pa` bit 39 is set.
- R11: With `sw_status_we` high and no recorded fault in the same cycle, `status` takes `sw_status_wdata` on the next edge. A recorded fault in the same cycle wins over the software write.
- R12: With `acc_valid` low, `fault` and `uncacheable` stay low and no register changes except through R11.
- R13: After a synchronous active-low reset, `status`, `fault_addr` and `tag_access` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | Access is a store |
| acc_priv | input | 1 | Access runs at supervisor privilege |
| acc_size | input | 2 | Log2 of operand size in bytes |
| acc_va_mask | input | 1 | 32-bit address masking enabled |
| acc_va | input | VA_W | Virtual address |
| acc_real | input | 1 | Real (untranslated-context) mode |
| acc_ctx_type | input | 2 | Context class: 0 primary, 1 secondary, 2 nucleus |
| acc_ctx | input | PG_SHIFT | Context number |
| acc_asi | input | ASI_W | Address-space identifier of the access |
| acc_nf_asi | input | 1 | Address space is a no-fault one |
| tlb_hit | input | 1 | TLB lookup hit |
| pg_priv | input | 1 | Page is privileged-only |
| pg_writable | input | 1 | Page permits stores |
| pg_nfo_only | input | 1 | Page is for no-fault accesses only |
| pg_side_effect | input | 1 | Page has side effects |
| pg_pa | input | PA_W | Translated physical address |
| sw_status_we | input | 1 | Software write of the status word |
| sw_status_wdata | input | SR_W | Data of that write |
| fault | output | 1 | A fault applies this cycle |
| fault_code | output | 4 | First applicable fault, per R1 |
| uncacheable | output | 1 | Translation must be uncacheable and strictly ordered |
| status | output | SR_W | Fault status word |
| fault_addr | output | VA_W | Fault address register |
| tag_access | output | VA_W | Tag-access register |

## Verification
The bench builds the block with its defaults: a 64-bit virtual address, a 13-bit page offset and context, an 8-bit address-space identifier and a 40-bit physical address. It sweeps all 1024 combinations of the ten single-bit access and page attributes against six address patterns. These patterns cover an aligned access, both misalignment sizes, a size that tolerates an odd address, a hole address and the same hole address with masking on. The sweep therefore reaches every priority pairing of the checks. Invalid cycles and software status writes are interleaved at fixed strides, so overflow, clear-by-software and software-versus-hardware collisions all occur within the same run.

// File: rtl/dmmu_fault_pkg.sv
// Shared types for the data MMU access checker.
// Assumes a single access per cycle; codes are fixed and visible to software.
package dmmu_fault_pkg;

    // Result of the priority chain, first applicable fault wins.
    typedef enum logic [3:0] {
        CHK_NONE      = 4'd0,
        CHK_MISALIGN  = 4'd1,
        CHK_VA_HOLE   = 4'd2,
        CHK_MISS_REAL = 4'd3,
        CHK_MISS_MMU  = 4'd4,
        CHK_PRIV      = 4'd5,
        CHK_PROT      = 4'd6,
        CHK_NFO       = 4'd7,
        CHK_SIDE      = 4'd8
    } chk_code_e;

    // Fault type field stored in the status word.
    typedef enum logic [5:0] {
        FT_OTHER       = 6'd0,
        FT_PRIV_VIOL   = 6'd1,
        FT_NFO_LOAD    = 6'd2,
        FT_VA_RANGE    = 6'd3,
        FT_SIDE_EFFECT = 6'd4,
        FT_ILLEGAL_ASI = 6'd5
    } ftype_e;

    // Status word field positions.
    localparam int SR_WRITE_BIT = 2;
    localparam int SR_CTX_LSB   = 4;
    localparam int SR_SE_BIT    = 6;
    localparam int SR_FT_LSB    = 7;
    localparam int SR_ASI_LSB   = 16;

    // What a checked access asks the register stage to record.
    typedef struct packed {
        logic   rec_status;
        logic   rec_tag;
        logic   wr;
        logic   se;
        ftype_e ft;
    } rec_req_s;

endpackage

// File: rtl/dmmu_check_chain.sv
// Combinational priority chain over one data access.
// Assumes the TLB result and page attributes are valid whenever tlb_hit is high.
module dmmu_check_chain
    import dmmu_fault_pkg::*;
#(
    parameter int          VA_W    = 64,
    parameter int          MASK_W  = 32,
    parameter logic [63:0] HOLE_LO = 64'h0000_8000_0000_0000,
    parameter logic [63:0] HOLE_HI = 64'hFFFF_7FFF_FFFF_FFFF
) (
    input  logic            valid,
    input  logic            write,
    input  logic            priv,
    input  logic [1:0]      size,
    input  logic            va_mask,
    input  logic [VA_W-1:0] va,
    input  logic            real_mode,
    input  logic            nf_asi,
    input  logic            hit,
    input  logic            pg_priv,
    input  logic            pg_wr,
    input  logic            pg_nfo,
    input  logic            pg_se,
    output logic [VA_W-1:0] eff_va,
    output chk_code_e       code,
    output rec_req_s        rec
);

    localparam logic [VA_W-1:0] LO_V = HOLE_LO[VA_W-1:0];
    localparam logic [VA_W-1:0] HI_V = HOLE_HI[VA_W-1:0];

    logic [2:0] size_mask;
    logic       misaligned;
    logic       in_hole;

    // Effective address and the two address-only checks.
    always_comb begin
        eff_va = va;
        if (va_mask) eff_va = {{(VA_W-MASK_W){1'b0}}, va[MASK_W-1:0]};
        case (size)
            2'd0:    size_mask = 3'b000;
            2'd1:    size_mask = 3'b001;
            2'd2:    size_mask = 3'b011;
            default: size_mask = 3'b111;
        endcase
        misaligned = |(va[2:0] & size_mask);
        in_hole    = !va_mask && (eff_va >= LO_V) && (eff_va <= HI_V);
    end

    // Priority chain: pick the first fault and what it records.
    always_comb begin
        code = CHK_NONE;
        rec  = '{rec_status: 1'b0, rec_tag: 1'b0, wr: 1'b0, se: 1'b0, ft: FT_OTHER};
        if (!valid) begin
            code = CHK_NONE;
        end else if (misaligned) begin
            code = CHK_MISALIGN;
            rec.rec_status = 1'b1;
        end else if (in_hole) begin
            code = CHK_VA_HOLE;
            rec.rec_status = 1'b1;
            rec.se = 1'b1;
            rec.ft = FT_VA_RANGE;
        end else if (!hit) begin
            code = real_mode ? CHK_MISS_REAL : CHK_MISS_MMU;
            rec.rec_tag = 1'b1;
        end else begin
            rec.wr = write;
            rec.se = pg_se;
            if (!priv && pg_priv) begin
                code = CHK_PRIV;
                rec.ft = FT_PRIV_VIOL;
            end else if (write && !pg_wr) begin
                code = CHK_PROT;
                rec.ft = FT_OTHER;
            end else if (pg_nfo && !nf_asi) begin
                code = CHK_NFO;
                rec.ft = FT_NFO_LOAD;
            end else if (pg_se && nf_asi) begin
                code = CHK_SIDE;
                rec.ft = FT_SIDE_EFFECT;
            end
            rec.rec_status = (code != CHK_NONE);
            rec.rec_tag    = (code != CHK_NONE);
            if (code == CHK_NONE) begin
                rec.wr = 1'b0;
                rec.se = 1'b0;
            end
        end
    end

endmodule

// File: rtl/dmmu_status_regs.sv
// Fault status, fault address and tag-access registers.
// Assumes at most one recording request per cycle; hardware beats software.
module dmmu_status_regs
    import dmmu_fault_pkg::*;
#(
    parameter int VA_W     = 64,
    parameter int PG_SHIFT = 13,
    parameter int ASI_W    = 8,
    localparam int SR_W    = SR_ASI_LSB + ASI_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  rec_req_s            rec,
    input  logic [1:0]          ctx_type,
    input  logic [ASI_W-1:0]    asi,
    input  logic [VA_W-1:0]     eff_va,
    input  logic [PG_SHIFT-1:0] tag_ctx,
    input  logic                sw_we,
    input  logic [SR_W-1:0]     sw_wdata,
    output logic [SR_W-1:0]     sfsr,
    output logic [VA_W-1:0]     sfar,
    output logic [VA_W-1:0]     tag
);

    logic [SR_W-1:0] next_word;

    // Compose the status word for a hardware-recorded fault.
    always_comb begin
        next_word = '0;
        next_word[0] = 1'b1;
        next_word[1] = sfsr[0];
        next_word[SR_WRITE_BIT] = rec.wr;
        next_word[SR_CTX_LSB +: 2] = ctx_type;
        next_word[SR_SE_BIT] = rec.se;
        next_word[SR_FT_LSB +: 6] = rec.ft;
        next_word[SR_ASI_LSB +: ASI_W] = asi;
    end

    // Status word and fault address: hardware record first, then software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sfsr <= '0;
            sfar <= '0;
        end else if (rec.rec_status) begin
            sfsr <= next_word;
            sfar <= eff_va;
        end else if (sw_we) begin
            sfsr <= sw_wdata;
        end
    end

    // Tag-access register: page number over context.
    always_ff @(posedge clk) begin
        if (!rst_n) tag <= '0;
        else if (rec.rec_tag) tag <= {eff_va[VA_W-1:PG_SHIFT], tag_ctx};
    end

endmodule

// File: rtl/dmmu_fault_check.sv
// Top: data MMU access checker with fault status capture.
// Assumes PG_SHIFT equals the context width and UC_BIT < PA_W.
module dmmu_fault_check
    import dmmu_fault_pkg::*;
#(
    parameter int          VA_W     = 64,
    parameter int          PG_SHIFT = 13,
    parameter int          ASI_W    = 8,
    parameter int          PA_W     = 40,
    parameter int          UC_BIT   = 39,
    parameter int          MASK_W   = 32,
    parameter logic [63:0] HOLE_LO  = 64'h0000_8000_0000_0000,
    parameter logic [63:0] HOLE_HI  = 64'hFFFF_7FFF_FFFF_FFFF,
    localparam int         SR_W     = SR_ASI_LSB + ASI_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_valid,
    input  logic                acc_write,
    input  logic                acc_priv,
    input  logic [1:0]          acc_size,
    input  logic                acc_va_mask,
    input  logic [VA_W-1:0]     acc_va,
    input  logic                acc_real,
    input  logic [1:0]          acc_ctx_type,
    input  logic [PG_SHIFT-1:0] acc_ctx,
    input  logic [ASI_W-1:0]    acc_asi,
    input  logic                acc_nf_asi,
    input  logic                tlb_hit,
    input  logic                pg_priv,
    input  logic                pg_writable,
    input  logic                pg_nfo_only,
    input  logic                pg_side_effect,
    input  logic [PA_W-1:0]     pg_pa,
    input  logic                sw_status_we,
    input  logic [SR_W-1:0]     sw_status_wdata,
    output logic                fault,
    output logic [3:0]          fault_code,
    output logic                uncacheable,
    output logic [SR_W-1:0]     status,
    output logic [VA_W-1:0]     fault_addr,
    output logic [VA_W-1:0]     tag_access
);

    logic [VA_W-1:0]     eff_va;
    chk_code_e           code;
    rec_req_s            rec;
    logic [PG_SHIFT-1:0] tag_ctx;

    dmmu_check_chain #(
        .VA_W(VA_W), .MASK_W(MASK_W), .HOLE_LO(HOLE_LO), .HOLE_HI(HOLE_HI)
    ) u_chain (
        .valid(acc_valid), .write(acc_write), .priv(acc_priv), .size(acc_size),
        .va_mask(acc_va_mask), .va(acc_va), .real_mode(acc_real), .nf_asi(acc_nf_asi),
        .hit(tlb_hit), .pg_priv(pg_priv), .pg_wr(pg_writable), .pg_nfo(pg_nfo_only),
        .pg_se(pg_side_effect), .eff_va(eff_va), .code(code), .rec(rec)
    );

    // Real mode tags carry context zero.
    assign tag_ctx = acc_real ? '0 : acc_ctx;

    dmmu_status_regs #(
        .VA_W(VA_W), .PG_SHIFT(PG_SHIFT), .ASI_W(ASI_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .rec(rec), .ctx_type(acc_ctx_type), .asi(acc_asi),
        .eff_va(eff_va), .tag_ctx(tag_ctx), .sw_we(sw_status_we),
        .sw_wdata(sw_status_wdata), .sfsr(status), .sfar(fault_addr), .tag(tag_access)
    );

    // Outputs of the chain and the ordering hint for clean translations.
    always_comb begin
        fault_code  = code;
        fault       = (code != CHK_NONE);
        uncacheable = acc_valid && (code == CHK_NONE) &&
                      (pg_side_effect || pg_pa[UC_BIT]);
    end

endmodule

// File: rtl/dmmu_fault_check_sva.sv
// Checker for dmmu_fault_check, attached by bind; observes ports only.
module dmmu_fault_check_sva #(
    parameter int VA_W = 64,
    parameter int SR_W = 24
) (
    input logic            clk,
    input logic            rst_n,
    input logic            acc_valid,
    input logic [1:0]      acc_size,
    input logic [VA_W-1:0] acc_va,
    input logic            tlb_hit,
    input logic            fault,
    input logic [3:0]      fault_code,
    input logic            uncacheable,
    input logic            sw_status_we,
    input logic [SR_W-1:0] sw_status_wdata,
    input logic [SR_W-1:0] status,
    input logic [VA_W-1:0] fault_addr
);

    logic       records;
    logic [2:0] szm;

    // Which cycles record status, and the size mask of the access.
    always_comb begin
        records = acc_valid && fault && (fault_code != 4'd3) && (fault_code != 4'd4);
        szm     = 3'((4'd1 << acc_size) - 4'd1);
    end

    assert_misalign_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && ((acc_va[2:0] & szm) != 3'd0) |-> fault && fault_code == 4'd1);

    assert_miss_only_on_nohit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_code == 4'd3 || fault_code == 4'd4) |-> !tlb_hit);

    assert_uc_only_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
        uncacheable |-> acc_valid && !fault);

    assert_no_overflow_loss_R6: assert property (@(posedge clk) disable iff (!rst_n)
        records && status[0] |=> status[1] && status[0]);

    assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !records |=> $stable(fault_addr));

    assert_sw_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sw_status_we && !records |=> status == $past(sw_status_wdata));

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> !fault && !uncacheable);

endmodule

bind dmmu_fault_check dmmu_fault_check_sva #(.VA_W(VA_W), .SR_W(SR_W)) u_sva (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_size(acc_size),
    .acc_va(acc_va), .tlb_hit(tlb_hit), .fault(fault), .fault_code(fault_code),
    .uncacheable(uncacheable), .sw_status_we(sw_status_we),
    .sw_status_wdata(sw_status_wdata), .status(status), .fault_addr(fault_addr)
);

// File: tb/test_dmmu_fault_check.sv
// Sweep bench for dmmu_fault_check; expected values come from the requirements.
module test_dmmu_fault_check;

    localparam int VA_W = 64, PG = 13, ASI_W = 8, PA_W = 40, SR_W = 24;
    localparam logic [63:0] LO = 64'h0000_8000_0000_0000;
    localparam logic [63:0] HI = 64'hFFFF_7FFF_FFFF_FFFF;

    logic clk = 1'b0, rst_n = 1'b0;
    logic acc_valid = 0, acc_write = 0, acc_priv = 0, acc_va_mask = 0, acc_real = 0;
    logic acc_nf_asi = 0, tlb_hit = 0, pg_priv = 0, pg_writable = 0, pg_nfo_only = 0;
    logic pg_side_effect = 0, sw_status_we = 0;
    logic [1:0] acc_size = 0, acc_ctx_type = 0;
    logic [VA_W-1:0] acc_va = '0;
    logic [PG-1:0] acc_ctx = '0;
    logic [ASI_W-1:0] acc_asi = '0;
    logic [PA_W-1:0] pg_pa = '0;
    logic [SR_W-1:0] sw_status_wdata = '0;
    logic fault, uncacheable;
    logic [3:0] fault_code;
    logic [SR_W-1:0] status;
    logic [VA_W-1:0] fault_addr, tag_access;

    int nchk = 0, nerr = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    dmmu_fault_check i_dmmu_fault_check (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_priv(acc_priv), .acc_size(acc_size), .acc_va_mask(acc_va_mask),
        .acc_va(acc_va), .acc_real(acc_real), .acc_ctx_type(acc_ctx_type),
        .acc_ctx(acc_ctx), .acc_asi(acc_asi), .acc_nf_asi(acc_nf_asi),
        .tlb_hit(tlb_hit), .pg_priv(pg_priv), .pg_writable(pg_writable),
        .pg_nfo_only(pg_nfo_only), .pg_side_effect(pg_side_effect), .pg_pa(pg_pa),
        .sw_status_we(sw_status_we), .sw_status_wdata(sw_status_wdata),
        .fault(fault), .fault_code(fault_code), .uncacheable(uncacheable),
        .status(status), .fault_addr(fault_addr), .tag_access(tag_access)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Model state of the three registers.
    logic [SR_W-1:0] m_sr = '0;
    logic [VA_W-1:0] m_far = '0, m_tag = '0;

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nerr++; nchk++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin : stim
        logic [VA_W-1:0] pva [6];
        logic [1:0]      psz [6];
        logic            pmk [6];
        pva[0] = 64'h0000_0001_2345_6000; psz[0] = 2'd3; pmk[0] = 0;
        pva[1] = 64'h0000_0001_2345_6004; psz[1] = 2'd3; pmk[1] = 0;
        pva[2] = 64'h0000_0001_2345_6003; psz[2] = 2'd1; pmk[2] = 0;
        pva[3] = 64'h0000_0001_2345_6003; psz[3] = 2'd0; pmk[3] = 0;
        pva[4] = 64'h0000_9000_0000_2008; psz[4] = 2'd3; pmk[4] = 0;
        pva[5] = 64'h0000_9000_0000_2008; psz[5] = 2'd3; pmk[5] = 1;

        repeat (3) @(posedge clk);
        #1;
        // R13: reset state
        chk("R13 status", 64'(status), 64'd0);
        chk("R13 fault_addr", fault_addr, 64'd0);
        chk("R13 tag_access", tag_access, 64'd0);
        @(negedge clk) rst_n = 1'b1;

        for (int p = 0; p < 6; p++) begin
            for (int c = 0; c < 1024; c++) begin
                int it;
                logic [3:0] ec;
                logic [VA_W-1:0] ev;
                logic euc, ewr, ese;
                logic [5:0] eft;
                it = p * 1024 + c;
                @(negedge clk);
                acc_valid      = (it % 5) != 4;
                acc_write      = c[0];
                acc_priv       = c[1];
                acc_nf_asi     = c[2];
                tlb_hit        = c[3];
                pg_priv        = c[4];
                pg_writable    = c[5];
                pg_nfo_only    = c[6];
                pg_side_effect = c[7];
                acc_real       = c[8];
                pg_pa          = {c[9], 39'h12_3456_7000};
                acc_va         = pva[p] ^ (64'(c[3:0]) << 20);
                acc_size       = psz[p];
                acc_va_mask    = pmk[p];
                acc_ctx_type   = 2'(it % 3);
                acc_ctx        = 13'(it * 37 + 5);
                acc_asi        = 8'(it * 11 + 3);
                sw_status_we   = (it % 7) == 3;
                sw_status_wdata = (it % 14 == 3) ? '0 : 24'(it * 977);

                // Expected result per R1..R4.
                ev = acc_va_mask ? {32'd0, acc_va[31:0]} : acc_va;
                ec = 4'd0;
                if (!acc_valid) ec = 4'd0;
                else if ((acc_va & ((64'd1 << acc_size) - 64'd1)) != 0) ec = 4'd1;
                else if (!acc_va_mask && ev >= LO && ev <= HI) ec = 4'd2;
                else if (!tlb_hit) ec = acc_real ? 4'd3 : 4'd4;
                else if (!acc_priv && pg_priv) ec = 4'd5;
                else if (acc_write && !pg_writable) ec = 4'd6;
                else if (pg_nfo_only && !acc_nf_asi) ec = 4'd7;
                else if (pg_side_effect && acc_nf_asi) ec = 4'd8;
                euc = acc_valid && ec == 0 && (pg_side_effect || pg_pa[39]);

                #1;
                case (ec)
                    4'd1:    chk("R2 misalign code", 64'(fault_code), 64'(ec));
                    4'd2:    chk("R3 hole code", 64'(fault_code), 64'(ec));
                    4'd3, 4'd4: chk("R4 miss code", 64'(fault_code), 64'(ec));
                    default: chk(acc_valid ? "R1 code" : "R12 idle code",
                                 64'(fault_code), 64'(ec));
                endcase
                chk("R1 fault flag", 64'(fault), 64'(ec != 0));
                chk("R10 uncacheable", 64'(uncacheable), 64'(euc));

                // Expected register updates per R5..R9, R11.
                ewr = 0; ese = 0; eft = 6'd0;
                case (ec)
                    4'd2: begin ese = 1; eft = 6'd3; end
                    4'd5: begin ewr = acc_write; ese = pg_side_effect; eft = 6'd1; end
                    4'd6: begin ewr = acc_write; ese = pg_side_effect; eft = 6'd0; end
                    4'd7: begin ewr = acc_write; ese = pg_side_effect; eft = 6'd2; end
                    4'd8: begin ewr = acc_write; ese = pg_side_effect; eft = 6'd4; end
                    default: ;
                endcase
                if (ec == 1 || ec == 2 || (ec >= 5 && ec <= 8)) begin
                    m_sr = {acc_asi, 3'b000, eft, ese, acc_ctx_type, 1'b0, ewr,
                            m_sr[0], 1'b1};
                    m_far = ev;
                end else if (sw_status_we) begin
                    m_sr = sw_status_wdata;
                end
                if (ec >= 3 && ec <= 8)
                    m_tag = {ev[63:13], acc_real ? 13'd0 : acc_ctx};

                @(posedge clk);
                #1;
                chk("R5 R6 R7 R11 status", 64'(status), 64'(m_sr));
                chk("R8 fault_addr", fault_addr, m_far);
                chk("R9 tag_access", tag_access, m_tag);
            end
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule